// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Table

This block decides whether a received CAN frame is kept. A table of 32-bit filter elements is held in registers. Each element carries one complete identifier, either standard or extended, plus the remote-request and extended-format bits the frame must show. The incoming identifier is placed in the same bit layout as an element and compared under a mask. A mask bit of 1 makes that bit count, and a mask bit of 0 makes it don't-care.

The number of active elements comes from a 4-bit length code. The low-numbered elements can each have a mask of their own. Every other element, and every element when per-element masking is switched off, shares one global mask. When more than one element matches, the lowest-numbered one wins. The result is a registered decision that carries the index of the winning element.

Software writes the table, the masks and the control word through a small write port. These writes take effect only while the controller is frozen. While frozen, the block also makes no decisions.

Top module: `can_id_filter`

## Requirements
- R1: Element layout: bit 31 holds the RTR value to match and bit 30 the IDE value to match. A standard identifier sits in bits 29:19 with bits 18:0 zero. An extended identifier sits in bits 29:1 with bit 0 zero. A frame is laid out the same way, so RTR and IDE are compared like identifier bits.
- R2: An element matches when every bit whose mask bit is 1 equals the frame's bit. Bits with mask 0 are ignored. An all-ones mask requires an exact match.
- R3: Only elements 0 to 8×(code+1)−1 take part, with the count capped at ELEM_MAX. Elements above that count never match.
- R4: With per-element masking on (control bit 8 = 1), element i < IMASK_NUM uses its own mask. Elements i ≥ IMASK_NUM always use the global mask. With control bit 8 = 0, every element uses the global mask.
- R5: When several active elements match, out_index reports the lowest-numbered one.
- R6: out_valid goes high for exactly one cycle, one clock after a rx_valid strobe seen while freeze is low. out_accept is 1 on a match. A frame that matches nothing gives out_accept = 0 and out_index = 0.
- R7: Writes are selected by cfg_sel: 0 writes element cfg_idx, 1 writes individual mask cfg_idx, 2 writes the global mask, and 3 writes the control word (bits 3:0 = length code, bit 8 = per-element masking enable). A write happens on the clock edge where cfg_we is high, and only while freeze is high. Writes made with freeze low are ignored.
- R8: A rx_valid strobe presented while freeze is high produces no decision.
- R9: After reset, all outputs are 0, every element is 0, every mask is all ones, the code is 0 and per-element masking is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Controller frozen: configuration writable, matching halted |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: element, individual mask, global mask, control |
| cfg_idx | input | log2(ELEM_MAX) | Element or mask index |
| cfg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 29 | Received identifier (bits 10:0 used for standard frames) |
| rx_ide | input | 1 | Frame uses an extended identifier |
| rx_rtr | input | 1 | Frame is a remote request |
| out_valid | output | 1 | Decision strobe |
| out_accept | output | 1 | Frame matched an element |
| out_index | output | log2(ELEM_MAX) | Lowest matching element, 0 on reject |

## Verification
A frame decision appears at the first rising edge after the rx_valid strobe. A configuration write is visible to frames presented after the edge that captures cfg_we. The bench drives every input on a falling edge and samples the decision on the next falling edge, which is exactly one register stage later. It does not sample frames on the same cycle as writes, so each expected value reflects the configuration that has already been written.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

  typedef logic [31:0] word_t;

  typedef enum logic [1:0] {
    SEL_ELEM  = 2'd0,
    SEL_IMASK = 2'd1,
    SEL_GMASK = 2'd2,
    SEL_CTRL  = 2'd3
  } cfg_sel_e;

  localparam int CODE_W       = 4;
  localparam int CTRL_IEN_BIT = 8;
  localparam int CNT_W        = 8;

  // Place a received identifier in the same layout as a table element.
  function automatic word_t align_key(input logic [28:0] id,
                                      input logic        ide,
                                      input logic        rtr);
    word_t k;
    k     = '0;
    k[31] = rtr;
    k[30] = ide;
    if (ide) k[29:1]  = id;
    else     k[29:19] = id[10:0];
    return k;
  endfunction

endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
  import can_flt_pkg::*;
#(
  parameter int ELEM_MAX  = 64,
  parameter int IMASK_NUM = 32,
  parameter int IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  word_t             cfg_wdata,
  output word_t             elem_q  [ELEM_MAX],
  output word_t             imask_q [IMASK_NUM],
  output word_t             gmask_q,
  output logic [CODE_W-1:0] code_q,
  output logic              ien_q
);

  logic     wr_ok;
  cfg_sel_e sel;

  assign wr_ok = cfg_we & freeze;
  assign sel   = cfg_sel_e'(cfg_sel);

  // Filter elements
  for (genvar i = 0; i < ELEM_MAX; i++) begin : g_elem
    logic en;
    assign en = wr_ok && (sel == SEL_ELEM) && (cfg_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  elem_q[i] <= '0;
      else if (en) elem_q[i] <= cfg_wdata;
    end
  end

  // Individual masks
  for (genvar i = 0; i < IMASK_NUM; i++) begin : g_imask
    logic en;
    assign en = wr_ok && (sel == SEL_IMASK) && (cfg_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  imask_q[i] <= '1;
      else if (en) imask_q[i] <= cfg_wdata;
    end
  end

  // Global mask and control word
  logic gm_en, ctrl_en;
  assign gm_en   = wr_ok && (sel == SEL_GMASK);
  assign ctrl_en = wr_ok && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gmask_q <= '1;
    else if (gm_en) gmask_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ien_q  <= 1'b0;
    end else if (ctrl_en) begin
      code_q <= cfg_wdata[CODE_W-1:0];
      ien_q  <= cfg_wdata[CTRL_IEN_BIT];
    end
  end

endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
  import can_flt_pkg::*;
#(
  parameter int ELEM_MAX  = 64,
  parameter int IMASK_NUM = 32
) (
  input  word_t              key,
  input  word_t              elem    [ELEM_MAX],
  input  word_t              imask   [IMASK_NUM],
  input  word_t              gmask,
  input  logic               ien,
  input  logic [CNT_W-1:0]   active_cnt,
  output logic [ELEM_MAX-1:0] hit
);

  for (genvar i = 0; i < ELEM_MAX; i++) begin : g_cmp
    word_t msk;
    logic  live;
    if (i < IMASK_NUM) begin : g_sel
      assign msk = ien ? imask[i] : gmask;
    end else begin : g_glb
      assign msk = gmask;
    end
    assign live   = active_cnt > CNT_W'(i);
    assign hit[i] = live && (((key ^ elem[i]) & msk) == '0);
  end

endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     hit,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Scan from the top so the lowest set bit is written last.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_flt_pkg::*;
#(
  parameter  int ELEM_MAX  = 64,
  parameter  int IMASK_NUM = 32,
  localparam int IDX_W     = $clog2(ELEM_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [31:0]      cfg_wdata,
  input  logic             rx_valid,
  input  logic [28:0]      rx_id,
  input  logic             rx_ide,
  input  logic             rx_rtr,
  output logic             out_valid,
  output logic             out_accept,
  output logic [IDX_W-1:0] out_index
);

  localparam logic [CNT_W-1:0] ELEM_CNT_MAX = CNT_W'(ELEM_MAX);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Configuration storage
  word_t             elem_q  [ELEM_MAX];
  word_t             imask_q [IMASK_NUM];
  word_t             gmask_q;
  logic [CODE_W-1:0] code_q;
  logic              ien_q;

  can_flt_regs #(
    .ELEM_MAX (ELEM_MAX),
    .IMASK_NUM(IMASK_NUM),
    .IDX_W    (IDX_W)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_q),
    .freeze   (freeze),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_idx  (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .elem_q   (elem_q),
    .imask_q  (imask_q),
    .gmask_q  (gmask_q),
    .code_q   (code_q),
    .ien_q    (ien_q)
  );

  // Active element count: 8 * (code + 1), capped at the table size
  logic [CNT_W-1:0] cnt_raw, active_cnt;
  assign cnt_raw    = {1'b0, code_q, 3'b000} + CNT_W'(8);
  assign active_cnt = (cnt_raw > ELEM_CNT_MAX) ? ELEM_CNT_MAX : cnt_raw;

  // Comparison
  word_t               key;
  logic [ELEM_MAX-1:0] hit;
  logic                any_hit;
  logic [IDX_W-1:0]    win_idx;

  assign key = align_key(rx_id, rx_ide, rx_rtr);

  can_flt_match #(
    .ELEM_MAX (ELEM_MAX),
    .IMASK_NUM(IMASK_NUM)
  ) i_match (
    .key       (key),
    .elem      (elem_q),
    .imask     (imask_q),
    .gmask     (gmask_q),
    .ien       (ien_q),
    .active_cnt(active_cnt),
    .hit       (hit)
  );

  can_flt_prio #(
    .N    (ELEM_MAX),
    .IDX_W(IDX_W)
  ) i_prio (
    .hit(hit),
    .any(any_hit),
    .idx(win_idx)
  );

  // Decision register: next state
  logic             nxt_valid, nxt_accept;
  logic [IDX_W-1:0] nxt_index;

  always_comb begin
    nxt_valid  = rx_valid & ~freeze;
    nxt_accept = nxt_valid & any_hit;
    nxt_index  = nxt_accept ? win_idx : '0;
  end

  // Decision register: state
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
      out_index  <= '0;
    end else begin
      out_valid  <= nxt_valid;
      out_accept <= nxt_accept;
      out_index  <= nxt_index;
    end
  end

endmodule

// File: rtl/can_flt_checker.sv
module can_flt_checker #(
  parameter int IDX_W = 6,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_q,
  input logic             freeze,
  input logic             rx_valid,
  input logic             out_valid,
  input logic             out_accept,
  input logic [IDX_W-1:0] out_index,
  input logic [7:0]       active_cnt,
  input logic [CW-1:0]    code_q,
  input logic             ien_q
);

  // R6
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rx_valid && !freeze) |=> out_valid);

  // R8
  frozen_silent_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (freeze || !rx_valid) |=> !out_valid);

  // R6
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_accept |-> out_valid);

  // R6
  reject_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_accept) |-> (out_index == '0));

  // R3
  index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_accept |-> (8'(out_index) < $past(active_cnt)));

  // R7
  ctrl_held_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !freeze |=> ($stable(code_q) && $stable(ien_q)));

endmodule

bind can_id_filter can_flt_checker #(
  .IDX_W(IDX_W),
  .CW   (can_flt_pkg::CODE_W)
) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .freeze    (freeze),
  .rx_valid  (rx_valid),
  .out_valid (out_valid),
  .out_accept(out_accept),
  .out_index (out_index),
  .active_cnt(active_cnt),
  .code_q    (code_q),
  .ien_q     (ien_q)
);

// File: tb/test_can_id_filter.sv
`timescale 1ns/1ps
module test_can_id_filter;

  localparam int NE = 64;
  localparam int NI = 32;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          freeze, cfg_we, rx_valid, rx_ide, rx_rtr;
  logic [1:0]    cfg_sel;
  logic [IW-1:0] cfg_idx;
  logic [31:0]   cfg_wdata;
  logic [28:0]   rx_id;
  logic          out_valid, out_accept;
  logic [IW-1:0] out_index;

  always #2 clk = ~clk;

  can_id_filter #(.ELEM_MAX(NE), .IMASK_NUM(NI)) i_can_id_filter (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
    .out_valid(out_valid), .out_accept(out_accept), .out_index(out_index)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Bench model of the configuration
  logic [31:0] m_elem [NE];
  logic [31:0] m_im   [NI];
  logic [31:0] m_gm;
  int          m_code;
  bit          m_ien;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_key(input logic [28:0] id, input bit ide, input bit rtr);
    if (ide) return {rtr, 1'b1, id, 1'b0};
    return {rtr, 1'b0, id[10:0], 19'd0};
  endfunction

  function automatic void ref_eval(input logic [28:0] id, input bit ide, input bit rtr,
                                   output bit acc, output int idx);
    logic [31:0] k, m;
    int cnt;
    k   = mk_key(id, ide, rtr);
    cnt = 8 * (m_code + 1);
    if (cnt > NE) cnt = NE;
    acc = 0;
    idx = 0;
    for (int i = 0; i < cnt; i++) begin
      m = (m_ien && i < NI) ? m_im[i] : m_gm;
      if (((k ^ m_elem[i]) & m) == 32'd0) begin
        acc = 1;
        idx = i;
        return;
      end
    end
  endfunction

  task automatic wr(input int sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_idx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (freeze) begin
      case (sel)
        0: m_elem[idx] = d;
        1: if (idx < NI) m_im[idx] = d;
        2: m_gm = d;
        default: begin m_code = int'(d[3:0]); m_ien = d[8]; end
      endcase
    end
  endtask

  task automatic set_frz(input bit f);
    @(negedge clk);
    freeze = f;
  endtask

  // Present one frame and check the decision one clock later.
  task automatic frame(input logic [28:0] id, input bit ide, input bit rtr, input string req);
    bit acc; int idx; bit ev;
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_ide = ide; rx_rtr = rtr;
    ev = !freeze;
    ref_eval(id, ide, rtr, acc, idx);
    if (!ev) begin acc = 0; idx = 0; end
    @(negedge clk);
    rx_valid = 0;
    chk(out_valid == ev, req, "valid", int'(out_valid), int'(ev));
    chk(out_accept == acc, req, "accept", int'(out_accept), int'(acc));
    chk(int'(out_index) == idx, req, "index", int'(out_index), idx);
  endtask

  function automatic logic [31:0] std_el(input int id, input bit rtr);
    return {rtr, 1'b0, 11'(id), 19'd0};
  endfunction

  function automatic logic [31:0] rnd_el();
    bit ide, rtr;
    ide = 1'($urandom);
    rtr = 1'($urandom);
    if (ide) return {rtr, 1'b1, 29'($urandom), 1'b0};
    return {rtr, 1'b0, 11'($urandom), 19'd0};
  endfunction

  function automatic logic [31:0] rnd_mask();
    return ~($urandom & $urandom & $urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; freeze = 0; cfg_we = 0; cfg_sel = 0; cfg_idx = 0; cfg_wdata = 0;
    rx_valid = 0; rx_id = 0; rx_ide = 0; rx_rtr = 0;
    for (int i = 0; i < NE; i++) m_elem[i] = 32'd0;
    for (int i = 0; i < NI; i++) m_im[i] = 32'hFFFF_FFFF;
    m_gm = 32'hFFFF_FFFF; m_code = 0; m_ien = 0;
    repeat (3) @(negedge clk);
    // R9 reset state of the outputs
    chk(out_valid == 0 && out_accept == 0 && out_index == 0, "R9", "outputs",
        int'({out_valid, out_accept}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R9 reset table is zero with exact masks: std id 0 hits element 0, id 1 misses
    frame(29'd0, 0, 0, "R9");
    frame(29'd1, 0, 0, "R9");

    // Directed table, code 2 -> 24 elements, per-element masks on
    set_frz(1);
    wr(3, 0, 32'h0000_0102);
    wr(0, 0, std_el(12'h055, 0));
    wr(0, 1, {2'b01, 29'h0F00_0F56, 1'b0});
    wr(0, 2, std_el(12'h059, 1));
    for (int i = 3; i < 24; i++) wr(0, i, std_el(12'h100 + i, 0));
    wr(0, 30, std_el(12'h3AA, 0));
    set_frz(0);
    frame(29'h055, 0, 0, "R1");
    frame(29'h0F00_0F56, 1, 0, "R1");
    frame(29'h056, 1, 0, "R1");
    frame(29'h059, 0, 0, "R1");
    frame(29'h059, 0, 1, "R1");
    frame(29'h110, 0, 0, "R6");
    frame(29'h3AA, 0, 0, "R3");
    frame(29'h7FF, 0, 0, "R6");

    // R8 frame while frozen gives no decision
    set_frz(1);
    frame(29'h055, 0, 0, "R8");
    set_frz(0);

    // R7 write with freeze low is ignored
    wr(0, 5, std_el(12'h3BB, 0));
    frame(29'h3BB, 0, 0, "R7");
    frame(29'h105, 0, 0, "R7");

    // R3 longer table exposes element 30
    set_frz(1);
    wr(3, 0, 32'h0000_0103);
    set_frz(0);
    frame(29'h3AA, 0, 0, "R3");

    // R2 masked low nibble on element 3; R5 lowest index wins over element 7
    set_frz(1);
    wr(1, 3, 32'hFFFF_FFFF ^ (32'hF << 19));
    set_frz(0);
    frame(29'h10C, 0, 0, "R2");
    frame(29'h107, 0, 0, "R5");
    frame(29'h11C, 0, 0, "R2");

    // R4 global mask: per-element masks off, then element above IMASK_NUM
    set_frz(1);
    wr(3, 0, 32'h0000_0005);
    set_frz(0);
    frame(29'h10C, 0, 0, "R4");
    set_frz(1);
    wr(2, 0, 32'hFFFF_FFFF ^ (32'h1 << 19));
    wr(3, 0, 32'h0000_0105);
    wr(0, 40, std_el(12'h2A0, 0));
    set_frz(0);
    frame(29'h2A1, 0, 0, "R4");
    frame(29'h2A2, 0, 0, "R4");

    // Random tables and frames
    for (int r = 0; r < 4; r++) begin
      set_frz(1);
      wr(3, 0, {23'd0, 1'($urandom), 4'd0, 4'($urandom % 8)});
      for (int i = 0; i < NE; i++) wr(0, i, rnd_el());
      for (int i = 0; i < NI; i++) wr(1, i, rnd_mask());
      wr(2, 0, rnd_mask());
      set_frz(0);
      for (int f = 0; f < 300; f++) begin
        logic [31:0] e;
        logic [28:0] id;
        bit ide, rtr;
        if ($urandom % 10 < 6) begin
          e   = m_elem[$urandom % NE];
          if ($urandom % 3 == 0) e = e ^ (32'h1 << ($urandom % 32));
          rtr = e[31]; ide = e[30];
          id  = ide ? e[29:1] : {18'd0, e[29:19]};
        end else begin
          ide = 1'($urandom); rtr = 1'($urandom);
          id  = 29'($urandom);
        end
        frame(id, ide, rtr, "R2");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule